// File: doc/BRIEF.md
# Prescaled Event Timer with Byte and Word Overflow Flags

This block is a 16-bit up-counter, kept as a high byte and a low byte, that advances only at the end of a machine cycle. A machine cycle is twelve clocks long by default. The counter counts one of two sources through a prescaler that divides by 1, 2, 4 or 8. The first source is the internal machine-cycle tick. The second is rising edges on an external count pin. Software cannot load the counter. It returns to zero on system reset, when an enabled rising edge arrives on the external reset pin, or while the idle signal is held. A change of source or division factor restarts the prescaler.

There are two sticky flags. The byte flag records a wrap of the low byte, and the wide flag records a wrap of the whole counter. Either flag can drive one shared interrupt request, according to two select inputs. Each flag clears only through its own clear strobe.

The external count pin is watched by a small edge detector with two states. LVL_HIGH is the reset state and LVL_LOW is the other. At each sample strobe a low sample moves LVL_HIGH to LVL_LOW, and a high sample moves LVL_LOW to LVL_HIGH. Only the LVL_LOW to LVL_HIGH transition reports a rising edge. The reset pin uses the same detector, sampled on every clock.

Top module: `evtmr_top`

## Requirements
- R1: Source select `src_sel` sets the source. With 00 or 10 the counter holds its value. With 01 it advances once per machine cycle of 12 clocks. With 11 it advances on edges of the count pin. The counter changes only at the last clock of a machine cycle.
- R2: `div_sel` codes 00, 01, 10 and 11 give one counter step per 1, 2, 4 and 8 source ticks. After a prescaler restart, the first step comes after a full division period.
- R3: Any change of `src_sel` or `div_sel` restarts the prescaler and drops count-pin edges that have not yet been counted.
- R4: The count pin passes through two flip-flops and is then sampled at clock phases 2 and 8 of each machine cycle; phase 0 is the first clock after reset. A rising edge is a low sample followed by a high sample, so the pin gives at most one count per machine cycle.
- R5: An edge found at the phase-2 sample is counted at the end of the next machine cycle. An edge found at the phase-8 sample is counted one machine cycle later.
- R6: When `xrst_en` is 1, a rising edge on `reset_pin` (after a two-flop synchronizer) clears the counter and the prescaler. When `xrst_en` is 0, the pin has no effect.
- R7: A low-byte wrap sets `flag_byte` at the end of the next machine cycle. A full 16-bit wrap sets both `flag_wide` and `flag_byte` at that same point.
- R8: `irq` is high exactly when (`flag_byte` and `sel_byte_irq`) or (`flag_wide` and `sel_wide_irq`).
- R9: Flags clear only on `clr_byte` or `clr_wide`. A clear strobe in the cycle that sets the flag leaves the flag set.
- R10: While `idle` is 1, the counter and prescaler are held at zero and do not count.
- R11: After reset the count is 0 and both flags and `irq` are 0.
- R12: `count` is the live value with no read latch. A low-byte carry reaches the high byte in the same clock, and the value moves by at most one per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| src_sel | input | 2 | Count source select |
| div_sel | input | 2 | Prescaler division code |
| xrst_en | input | 1 | Enables the external reset pin |
| sel_byte_irq | input | 1 | Lets the byte flag drive irq |
| sel_wide_irq | input | 1 | Lets the wide flag drive irq |
| count_pin | input | 1 | External count input |
| reset_pin | input | 1 | External counter reset input |
| idle | input | 1 | Holds counter and prescaler at zero |
| clr_byte | input | 1 | Clear strobe for the byte flag |
| clr_wide | input | 1 | Clear strobe for the wide flag |
| count | output | 16 | Live counter value |
| flag_byte | output | 1 | Low-byte wrap flag |
| flag_wide | output | 1 | Full-counter wrap flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest state to reach from the ports is the full-counter wrap. The counter cannot be loaded, so reaching it takes 65536 steps of at least one machine cycle each. The bench therefore builds the block with a 4-bit byte width, which makes the whole counter wrap after 256 internal ticks. This exercises the same carry and flag logic. The other hard case is sample alignment. Count-pin edges are placed at both sample points by shifting a square wave of one machine-cycle period by half a cycle. A reference model predicts when each counter step must land.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_TICK = 2'b01,
        SRC_TEST = 2'b10,
        SRC_PIN  = 2'b11
    } src_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;
endpackage

// File: rtl/evtmr_phase.sv
module evtmr_phase #(
    parameter int CYC_LEN = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic samp_a_o,
    output logic samp_b_o,
    output logic end_o
);
    localparam int PW     = $clog2(CYC_LEN);
    localparam int PH_A   = CYC_LEN / 6;
    localparam int PH_B   = CYC_LEN / 2 + CYC_LEN / 6;
    localparam int PH_END = CYC_LEN - 1;

    logic [PW-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ph_q <= '0;
        else if (ph_q == PW'(PH_END))
            ph_q <= '0;
        else
            ph_q <= ph_q + 1'b1;
    end

    always_comb begin
        samp_a_o = (ph_q == PW'(PH_A));
        samp_b_o = (ph_q == PW'(PH_B));
        end_o    = (ph_q == PW'(PH_END));
    end
endmodule

// File: rtl/evtmr_edge.sv
module evtmr_edge
    import evtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic en_i,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    lvl_e                   st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    assign level = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= LVL_HIGH;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        rise_o = 1'b0;
        if (en_i) begin
            unique case (st_q)
                LVL_LOW: begin
                    if (level) begin
                        st_d   = LVL_HIGH;
                        rise_o = 1'b1;
                    end
                end
                LVL_HIGH: begin
                    if (!level)
                        st_d = LVL_LOW;
                end
            endcase
        end
    end

    assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o)
        else $error("two rising edges reported back to back");
endmodule

// File: rtl/evtmr_presc.sv
module evtmr_presc #(
    parameter int DIV_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [DIV_BITS-1:0] div_i,
    input  logic                clr_i,
    output logic                pass_o
);
    localparam int PC_W = (1 << DIV_BITS) - 1;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] mask;
    logic            done;

    always_comb begin
        mask   = (PC_W'(1) << div_i) - PC_W'(1);
        done   = ((pc_q & mask) == mask);
        pass_o = tick_i && done && !clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc_q <= '0;
        else if (clr_i)
            pc_q <= '0;
        else if (tick_i)
            pc_q <= done ? '0 : pc_q + 1'b1;
    end
endmodule

// File: rtl/evtmr_core.sv
module evtmr_core
    import evtmr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int DIV_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  samp_a_i,
    input  logic                  samp_b_i,
    input  logic                  end_i,
    input  logic                  cnt_rise_i,
    input  logic                  rst_rise_i,
    input  src_e                  src_i,
    input  logic [DIV_BITS-1:0]   div_i,
    input  logic                  xrst_en_i,
    input  logic                  idle_i,
    input  logic                  clr_byte_i,
    input  logic                  clr_wide_i,
    output logic [2*BYTE_W-1:0]   cnt_o,
    output logic                  flag_byte_o,
    output logic                  flag_wide_o
);
    localparam int CW    = 2 * BYTE_W;
    localparam int CFG_W = 2 + DIV_BITS;

    logic [BYTE_W-1:0] lo_q, hi_q;
    logic [CW-1:0]     cnt_w;
    logic [CFG_W-1:0]  cfg_q;
    logic              cfg_chg, xrst, cnt_clr, pre_clr;
    logic              hit_a, hit_b, due_now, due_next;
    logic              pin_tick, src_tick, inc;
    logic              byte_ovf, wide_ovf;
    logic              pend_b, pend_w;
    logic              flag_b_q, flag_w_q;

    // configuration change detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else
            cfg_q <= {src_i, div_i};
    end

    always_comb begin
        cfg_chg = ({src_i, div_i} != cfg_q);
        xrst    = rst_rise_i && xrst_en_i;
        cnt_clr = xrst || idle_i;
        pre_clr = cfg_chg || cnt_clr;
    end

    // edge-to-count latency pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_a    <= 1'b0;
            hit_b    <= 1'b0;
            due_now  <= 1'b0;
            due_next <= 1'b0;
        end else if (pre_clr) begin
            hit_a    <= 1'b0;
            hit_b    <= 1'b0;
            due_now  <= 1'b0;
            due_next <= 1'b0;
        end else begin
            if (samp_a_i && cnt_rise_i)
                hit_a <= 1'b1;
            if (samp_b_i && cnt_rise_i)
                hit_b <= 1'b1;
            if (end_i) begin
                due_now  <= hit_a || due_next;
                due_next <= hit_b;
                hit_a    <= 1'b0;
                hit_b    <= 1'b0;
            end
        end
    end

    assign pin_tick = end_i && due_now;

    always_comb begin
        unique case (src_i)
            SRC_OFF:  src_tick = 1'b0;
            SRC_TICK: src_tick = end_i;
            SRC_TEST: src_tick = 1'b0;
            SRC_PIN:  src_tick = pin_tick;
        endcase
    end

    evtmr_presc #(.DIV_BITS(DIV_BITS)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (src_tick),
        .div_i  (div_i),
        .clr_i  (pre_clr),
        .pass_o (inc)
    );

    // split counter
    always_comb begin
        byte_ovf = inc && (lo_q == '1);
        wide_ovf = byte_ovf && (hi_q == '1);
        cnt_w    = {hi_q, lo_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (cnt_clr) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (inc) begin
            lo_q <= lo_q + 1'b1;
            if (lo_q == '1)
                hi_q <= hi_q + 1'b1;
        end
    end

    // overflow reporting, one machine cycle late
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_b <= 1'b0;
            pend_w <= 1'b0;
        end else if (end_i) begin
            pend_b <= byte_ovf;
            pend_w <= wide_ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_b_q <= 1'b0;
            flag_w_q <= 1'b0;
        end else begin
            if (end_i && (pend_b || pend_w))
                flag_b_q <= 1'b1;
            else if (clr_byte_i)
                flag_b_q <= 1'b0;
            if (end_i && pend_w)
                flag_w_q <= 1'b1;
            else if (clr_wide_i)
                flag_w_q <= 1'b0;
        end
    end

    assign cnt_o       = cnt_w;
    assign flag_byte_o = flag_b_q;
    assign flag_wide_o = flag_w_q;

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!end_i && !cnt_clr) |=> $stable(cnt_w))
        else $error("count moved outside a machine-cycle end");

    assert_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && !cnt_clr) |=> (cnt_w == $past(cnt_w) || cnt_w == $past(cnt_w) + CW'(1)))
        else $error("count jumped by more than one");

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_i |=> (cnt_w == '0))
        else $error("count not zero while idle");

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_b_q && !clr_byte_i) |=> flag_b_q)
        else $error("byte flag dropped without a clear");

    assert_wide_sets_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_w_q) |-> flag_b_q)
        else $error("wide flag set without byte flag");
endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
    import evtmr_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int CYC_LEN = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          src_sel,
    input  logic [1:0]          div_sel,
    input  logic                xrst_en,
    input  logic                sel_byte_irq,
    input  logic                sel_wide_irq,
    input  logic                count_pin,
    input  logic                reset_pin,
    input  logic                idle,
    input  logic                clr_byte,
    input  logic                clr_wide,
    output logic [2*BYTE_W-1:0] count,
    output logic                flag_byte,
    output logic                flag_wide,
    output logic                irq
);
    logic samp_a, samp_b, cyc_end;
    logic cnt_rise, rst_rise;

    evtmr_phase #(.CYC_LEN(CYC_LEN)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_a_o (samp_a),
        .samp_b_o (samp_b),
        .end_o    (cyc_end)
    );

    evtmr_edge #(.SYNC_STAGES(2)) u_cnt_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (count_pin),
        .en_i   (samp_a || samp_b),
        .rise_o (cnt_rise)
    );

    evtmr_edge #(.SYNC_STAGES(2)) u_rst_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (reset_pin),
        .en_i   (1'b1),
        .rise_o (rst_rise)
    );

    evtmr_core #(.BYTE_W(BYTE_W), .DIV_BITS(2)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .samp_a_i    (samp_a),
        .samp_b_i    (samp_b),
        .end_i       (cyc_end),
        .cnt_rise_i  (cnt_rise),
        .rst_rise_i  (rst_rise),
        .src_i       (src_e'(src_sel)),
        .div_i       (div_sel),
        .xrst_en_i   (xrst_en),
        .idle_i      (idle),
        .clr_byte_i  (clr_byte),
        .clr_wide_i  (clr_wide),
        .cnt_o       (count),
        .flag_byte_o (flag_byte),
        .flag_wide_o (flag_wide)
    );

    assign irq = (flag_byte && sel_byte_irq) || (flag_wide && sel_wide_irq);
endmodule

// File: tb/evtmr_top_test.sv
module evtmr_top_test;
    localparam int BW = 4;
    localparam int CW = 2 * BW;
    localparam int BM = (1 << BW) - 1;
    localparam int CM = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic [1:0] div_sel = 2'b00;
    logic xrst_en = 1'b0;
    logic sel_byte_irq = 1'b0;
    logic sel_wide_irq = 1'b0;
    logic count_pin = 1'b0;
    logic reset_pin = 1'b0;
    logic idle = 1'b0;
    logic clr_byte = 1'b0;
    logic clr_wide = 1'b0;
    logic [CW-1:0] count;
    logic flag_byte, flag_wide, irq;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    string cur_req = "R11";

    evtmr_top #(.BYTE_W(BW), .CYC_LEN(12)) uut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .div_sel(div_sel),
        .xrst_en(xrst_en), .sel_byte_irq(sel_byte_irq), .sel_wide_irq(sel_wide_irq),
        .count_pin(count_pin), .reset_pin(reset_pin), .idle(idle),
        .clr_byte(clr_byte), .clr_wide(clr_wide),
        .count(count), .flag_byte(flag_byte), .flag_wide(flag_wide), .irq(irq)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    int m_ph, m_cyc, m_s1, m_s2, m_lvl, r_s1, r_s2, r_lvl;
    int m_pc, m_cnt, pend_b, pend_w, mfb, mfw, prev_cfg;
    bit dueb[4];

    task automatic model_reset();
        m_ph = 0; m_cyc = 0; m_s1 = 0; m_s2 = 0; m_lvl = 1;
        r_s1 = 0; r_s2 = 0; r_lvl = 1; m_pc = 0; m_cnt = 0;
        pend_b = 0; pend_w = 0; mfb = 0; mfw = 0; prev_cfg = 0;
        for (int i = 0; i < 4; i++) dueb[i] = 0;
    endtask

    task automatic model_step();
        int eoc, sa, sb, rc, rr, cfg, chg, cc, pre, tick, src, mask, done, inc, bov, wov;
        eoc = (m_ph == 11); sa = (m_ph == 2); sb = (m_ph == 8);
        rc = 0;
        if (sa || sb) begin
            if (m_s2 && !m_lvl) rc = 1;
            m_lvl = m_s2;
        end
        rr = (r_s2 && !r_lvl) ? 1 : 0;
        r_lvl = r_s2;
        cfg = int'(src_sel) * 4 + int'(div_sel);
        chg = (cfg != prev_cfg);
        prev_cfg = cfg;
        cc = (rr && xrst_en) || idle;
        pre = chg || cc;
        if (rc) dueb[(m_cyc + (sa ? 1 : 2)) % 4] = 1;
        tick = eoc && dueb[m_cyc % 4];
        if (eoc) dueb[m_cyc % 4] = 0;
        if (pre) for (int i = 0; i < 4; i++) dueb[i] = 0;
        src = (src_sel == 2'b01) ? eoc : (src_sel == 2'b11) ? tick : 0;
        mask = (1 << int'(div_sel)) - 1;
        done = ((m_pc & mask) == mask);
        inc = src && done && !pre;
        if (pre) m_pc = 0;
        else if (src) m_pc = done ? 0 : m_pc + 1;
        bov = inc && ((m_cnt & BM) == BM);
        wov = inc && (m_cnt == CM);
        if (cc) m_cnt = 0;
        else if (inc) m_cnt = (m_cnt + 1) & CM;
        if (eoc && (pend_b || pend_w)) mfb = 1; else if (clr_byte) mfb = 0;
        if (eoc && pend_w) mfw = 1; else if (clr_wide) mfw = 0;
        if (eoc) begin pend_b = bov; pend_w = wov; end
        m_s2 = m_s1; m_s1 = count_pin;
        r_s2 = r_s1; r_s1 = reset_pin;
        if (eoc) begin m_ph = 0; m_cyc++; end else m_ph++;
    endtask

    task automatic check(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
        #5;
        if (rst_n && !finished) begin
            check("count", int'(count), m_cnt);
            check("flag_byte", int'(flag_byte), mfb);
            check("flag_wide", int'(flag_wide), mfw);
            check("irq R8", int'(irq), (mfb && sel_byte_irq) || (mfw && sel_wide_irq));
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic square(input int half, input int reps);
        for (int i = 0; i < reps; i++) begin
            count_pin = 1'b1; wait_n(half);
            count_pin = 1'b0; wait_n(half);
        end
    endtask

    task automatic pulse_reset_pin();
        reset_pin = 1'b1; wait_n(5);
        reset_pin = 1'b0; wait_n(5);
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        @(posedge clk); #6;
        cur_req = "R11";
        check("reset count R11", int'(count), 0);
        check("reset flags R11", int'({flag_byte, flag_wide, irq}), 0);
        @(negedge clk);

        cur_req = "R1 internal tick";
        src_sel = 2'b01; wait_n(300);
        cur_req = "R2 divide";
        div_sel = 2'b01; wait_n(200);
        div_sel = 2'b10; wait_n(250);
        div_sel = 2'b11; wait_n(400);
        cur_req = "R3 restart";
        wait_n(30); div_sel = 2'b10; wait_n(5); div_sel = 2'b11; wait_n(60);
        src_sel = 2'b11; wait_n(7); src_sel = 2'b01; wait_n(100);
        cur_req = "R1 hold";
        div_sel = 2'b00; src_sel = 2'b00; wait_n(200);
        src_sel = 2'b10; wait_n(200);

        cur_req = "R4 pin";
        src_sel = 2'b11; div_sel = 2'b00;
        square(7, 20); square(2, 40); square(1, 40); square(13, 10);
        cur_req = "R5 alignment";
        square(6, 20); wait_n(3); square(6, 20); wait_n(6); square(6, 20);
        cur_req = "R2 pin divide";
        div_sel = 2'b01; square(9, 30);
        div_sel = 2'b11; square(5, 60);

        cur_req = "R6 ext reset";
        src_sel = 2'b01; div_sel = 2'b00; wait_n(100);
        xrst_en = 1'b0; pulse_reset_pin();
        check("count kept with reset disabled R6", int'(count) != 0 ? 1 : 0, 1);
        xrst_en = 1'b1; reset_pin = 1'b1; wait_n(4);
        check("count cleared by reset pin R6", int'(count), 0);
        reset_pin = 1'b0; wait_n(5);
        src_sel = 2'b11; square(6, 10); pulse_reset_pin(); square(6, 10);
        src_sel = 2'b01; xrst_en = 1'b1; pulse_reset_pin(); xrst_en = 1'b0;

        cur_req = "R7 R8 R12 wraps";
        sel_byte_irq = 1'b1;
        for (int k = 0; k < 36; k++) begin
            wait_n(97);
            if (k % 3 == 0) begin clr_byte = 1'b1; wait_n(1); clr_byte = 1'b0; end
            if (k % 5 == 0) sel_wide_irq = ~sel_wide_irq;
            if (k % 7 == 0) sel_byte_irq = ~sel_byte_irq;
            if (k % 11 == 0) begin clr_wide = 1'b1; wait_n(1); clr_wide = 1'b0; end
        end
        cur_req = "R9 clear versus set";
        clr_byte = 1'b1; clr_wide = 1'b1; wait_n(450);
        clr_byte = 1'b0; clr_wide = 1'b0; wait_n(200);

        cur_req = "R10 idle";
        idle = 1'b1; wait_n(100);
        check("count held zero in idle R10", int'(count), 0);
        idle = 1'b0; wait_n(150);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL %s watchdog: got timeout expected completion", cur_req);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule